// File: doc/BRIEF.md
# DSP-to-ISA DMA Bus Bridge

This block is the glue that lets a signal processor with no DMA pins host an 8-bit ISA-style audio peripheral while a separate DMA controller moves sample data. On the host side it turns the processor's active-low I/O-space select and read/write strobes into the ISA I/O read and write strobes. It also inverts the peripheral's active-high interrupt request for the processor's interrupt pin, and it drives the peripheral's reset line.

Bus grant uses an edge-triggered handshake. When the DMA controller raises its bus request, the bridge pulls the processor's combined hold/interrupt input low. The processor takes that falling edge as an interrupt, tri-states its bus and idles inside the service routine, then drives its active-low hold acknowledge. The bridge passes that acknowledge to the controller as an active-high grant. When the controller drops its request, the hold input returns high and the processor takes the bus back on that rising edge.

A small ownership state machine follows the handshake. It forces the host-derived strobes inactive while the controller owns the bus, and it makes sure each request gives exactly one falling edge. Every asynchronous input passes through a `SYNC_STAGES`-deep synchronizer, and every output comes from a register.

Top module: `dsp_dma_bridge`

## Requirements
- R1: `isa_ior_n` goes low one clock after `dsp_io_sel_n` and `dsp_rd_n` are both sampled low while the bus belongs to the host. Otherwise it is high.
- R2: `isa_iow_n` is the registered OR of `dsp_io_sel_n` and `dsp_wr_n`, one clock late. It is low only when both were low and the bus belongs to the host.
- R3: A rising `dmac_hreq` drives `dsp_hold_n` low exactly `SYNC_STAGES`+1 clocks later (3 with defaults) and not before.
- R4: Dropping `dmac_hreq` returns `dsp_hold_n` high `SYNC_STAGES`+1 clocks later. This holds whether the grant has already arrived or not. If no grant had arrived, `bus_owner` stays 0.
- R5: `dmac_hlda` goes high `SYNC_STAGES`+1 clocks after `dsp_hack_n` goes low, but only while a hold is pending. An acknowledge with no pending hold is ignored, and `dmac_hlda` stays 0. `dmac_hlda` falls `SYNC_STAGES`+1 clocks after `dsp_hack_n` returns high.
- R6: `dsp_irq_n` is the inverse of `per_irq`, delayed by `SYNC_STAGES`+1 clocks.
- R7: `per_rst` is high one clock after `rst` or `host_rst` is high, and low one clock after both are low.
- R8: While `bus_owner` is 1, `isa_ior_n` and `isa_iow_n` are both high, whatever the host strobes do.
- R9: Each request gives exactly one falling edge on `dsp_hold_n`. A request raised again before the host has released its acknowledge keeps `dsp_hold_n` high until ownership returns to the host. The new falling edge then comes one clock later.
- R10: `bus_owner` encodes the owner as 0 for the host processor and 1 for the DMA controller. It is 1 from the grant until the host releases its acknowledge, and it equals `dmac_hlda`.
- R11: While `rst` is high, the outputs are `isa_ior_n`=1, `isa_iow_n`=1, `dsp_hold_n`=1, `dmac_hlda`=0, `dsp_irq_n`=1, `per_rst`=1 and `bus_owner`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| dsp_io_sel_n | input | 1 | Host I/O-space select, active low |
| dsp_rd_n | input | 1 | Host read strobe, active low |
| dsp_wr_n | input | 1 | Host write strobe, active low |
| dsp_hack_n | input | 1 | Host hold acknowledge, active low, asynchronous |
| dmac_hreq | input | 1 | DMA controller bus request, active high, asynchronous |
| per_irq | input | 1 | Peripheral interrupt request, active high, asynchronous |
| host_rst | input | 1 | Host-side peripheral reset request |
| isa_ior_n | output | 1 | ISA I/O read strobe, active low |
| isa_iow_n | output | 1 | ISA I/O write strobe, active low |
| dsp_hold_n | output | 1 | Host hold/interrupt input, active low |
| dmac_hlda | output | 1 | Hold acknowledge to DMA controller, active high |
| dsp_irq_n | output | 1 | Inverted peripheral interrupt to host |
| per_rst | output | 1 | Peripheral reset, active high |
| bus_owner | output | 1 | 0 = host owns bus, 1 = DMA controller owns bus |

## Verification
The strobe decode is tried with the select and strobe combinations one at a time. Only both-low pairs may pull a strobe, and a simultaneous read and write separates the two decodes. The handshake runs in four patterns:
- a full grant and release cycle, with the host strobes held active so that the blocking shows;
- an acknowledge that arrives with no request, which must be ignored;
- a request raised again while the release is pending, which must not give an early falling edge;
- a request withdrawn before the grant.

Latency checks taken one clock before and at the expected edge show that the synchronizer depth is exact.

// File: rtl/dsp_dma_pkg.sv
package dsp_dma_pkg;
  typedef enum logic [1:0] {
    ST_HOST = 2'd0,
    ST_ASK  = 2'd1,
    ST_DMA  = 2'd2,
    ST_GIVE = 2'd3
  } bus_st_e;

  localparam logic OWNER_HOST = 1'b0;
  localparam logic OWNER_DMA  = 1'b1;
endpackage

// File: rtl/dsp_dma_sync.sv
module dsp_dma_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsp_dma_strobe.sv
module dsp_dma_strobe (
  input  logic clk,
  input  logic rst,
  input  logic io_sel_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic block,
  output logic ior_n,
  output logic iow_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ior_n <= 1'b1;
      iow_n <= 1'b1;
    end else begin
      ior_n <= io_sel_n | rd_n | block;
      iow_n <= io_sel_n | wr_n | block;
    end
  end
endmodule

// File: rtl/dsp_dma_hold_fsm.sv
module dsp_dma_hold_fsm
  import dsp_dma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic hack_n_s,
  output logic hold_n,
  output logic hlda,
  output logic owner,
  output logic owner_nxt
);
  bus_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOST: if (req_s) st_d = ST_ASK;
      ST_ASK: begin
        if (!hack_n_s)  st_d = ST_DMA;
        else if (!req_s) st_d = ST_HOST;
      end
      ST_DMA:  if (!req_s) st_d = ST_GIVE;
      ST_GIVE: if (hack_n_s) st_d = ST_HOST;
      default: st_d = ST_HOST;
    endcase
  end

  assign owner_nxt = (st_d == ST_DMA || st_d == ST_GIVE) ? OWNER_DMA : OWNER_HOST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HOST;
      hold_n <= 1'b1;
      hlda   <= 1'b0;
      owner  <= OWNER_HOST;
    end else begin
      st_q   <= st_d;
      hold_n <= !(st_d == ST_ASK || st_d == ST_DMA);
      hlda   <= owner_nxt;
      owner  <= owner_nxt;
    end
  end
endmodule

// File: rtl/dsp_dma_bridge.sv
module dsp_dma_bridge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dsp_io_sel_n,
  input  logic dsp_rd_n,
  input  logic dsp_wr_n,
  input  logic dsp_hack_n,
  input  logic dmac_hreq,
  input  logic per_irq,
  input  logic host_rst,
  output logic isa_ior_n,
  output logic isa_iow_n,
  output logic dsp_hold_n,
  output logic dmac_hlda,
  output logic dsp_irq_n,
  output logic per_rst,
  output logic bus_owner
);
  localparam int unsigned NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b010;

  logic [NSYNC-1:0] async_in, synced;
  logic req_s, hack_n_s, irq_s, owner_nxt;

  assign async_in = {per_irq, dsp_hack_n, dmac_hreq};
  assign req_s    = synced[0];
  assign hack_n_s = synced[1];
  assign irq_s    = synced[2];

  dsp_dma_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(async_in), .q(synced)
  );

  dsp_dma_hold_fsm u_fsm (
    .clk(clk), .rst(rst), .req_s(req_s), .hack_n_s(hack_n_s),
    .hold_n(dsp_hold_n), .hlda(dmac_hlda), .owner(bus_owner), .owner_nxt(owner_nxt)
  );

  dsp_dma_strobe u_strb (
    .clk(clk), .rst(rst), .io_sel_n(dsp_io_sel_n), .rd_n(dsp_rd_n), .wr_n(dsp_wr_n),
    .block(owner_nxt), .ior_n(isa_ior_n), .iow_n(isa_iow_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_irq_n <= 1'b1;
      per_rst   <= 1'b1;
    end else begin
      dsp_irq_n <= ~irq_s;
      per_rst   <= host_rst;
    end
  end
endmodule

// File: rtl/dsp_dma_bridge_chk.sv
module dsp_dma_bridge_chk (
  input logic clk,
  input logic rst,
  input logic dsp_io_sel_n,
  input logic dsp_rd_n,
  input logic dsp_wr_n,
  input logic isa_ior_n,
  input logic isa_iow_n,
  input logic dsp_hold_n,
  input logic dmac_hlda,
  input logic per_rst,
  input logic bus_owner
);
  p_read_decode_r1: assert property (@(posedge clk) disable iff (rst)
    !isa_ior_n |-> $past(!dsp_io_sel_n && !dsp_rd_n));

  p_write_decode_r2: assert property (@(posedge clk) disable iff (rst)
    !isa_iow_n |-> $past(!dsp_io_sel_n && !dsp_wr_n));

  p_grant_after_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dmac_hlda) |-> $past(!dsp_hold_n));

  p_strobes_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    bus_owner |-> (isa_ior_n && isa_iow_n));

  p_fall_from_host_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(dsp_hold_n) |-> $past(!bus_owner));

  p_owner_matches_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_owner) |-> dmac_hlda);

  p_reset_line_r7: assert property (@(posedge clk)
    rst |=> per_rst);
endmodule

bind dsp_dma_bridge dsp_dma_bridge_chk u_chk (
  .clk(clk), .rst(rst), .dsp_io_sel_n(dsp_io_sel_n), .dsp_rd_n(dsp_rd_n),
  .dsp_wr_n(dsp_wr_n), .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
  .dsp_hold_n(dsp_hold_n), .dmac_hlda(dmac_hlda), .per_rst(per_rst),
  .bus_owner(bus_owner)
);

// File: tb/sim_dsp_dma_bridge.sv
module sim_dsp_dma_bridge;
  // output vector: {ior_n, iow_n, hold_n, hlda, irq_n, per_rst, owner}
  localparam logic [6:0] M_IOR = 7'b1000000, M_IOW = 7'b0100000, M_HLD = 7'b0010000,
                         M_HLA = 7'b0001000, M_IRQ = 7'b0000100, M_PRS = 7'b0000010,
                         M_OWN = 7'b0000001;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hack_n = 1'b1, hreq = 1'b0, irq = 1'b0, hrst = 1'b0;
  logic ior_n, iow_n, hold_n, hlda, irq_n, prst, owner;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int due; logic [6:0] mask; logic [6:0] val; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsp_dma_bridge u0 (
    .clk(clk), .rst(rst), .dsp_io_sel_n(sel_n), .dsp_rd_n(rd_n), .dsp_wr_n(wr_n),
    .dsp_hack_n(hack_n), .dmac_hreq(hreq), .per_irq(irq), .host_rst(hrst),
    .isa_ior_n(ior_n), .isa_iow_n(iow_n), .dsp_hold_n(hold_n), .dmac_hlda(hlda),
    .dsp_irq_n(irq_n), .per_rst(prst), .bus_owner(owner)
  );

  task automatic expect_in(int lat, logic [6:0] mask, logic [6:0] val, string tag);
    item_t it;
    it.due = cyc + lat; it.mask = mask; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    logic [6:0] got;
    got = {ior_n, iow_n, hold_n, hlda, irq_n, prst, owner};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if ((got & q[i].mask) !== (q[i].val & q[i].mask)) begin
          errors++;
          $display("FAIL %s: got %b expected %b (mask %b)", q[i].tag, got & q[i].mask,
                   q[i].val & q[i].mask, q[i].mask);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_in(1, 7'h7F, 7'b1110110, "R11 reset state");
    step(2);
    rst = 1'b0;
    expect_in(1, M_PRS, 7'b0, "R7 per_rst clears");
    step(2);
    hrst = 1'b1; expect_in(1, M_PRS, M_PRS, "R7 host_rst sets per_rst");
    step(1);
    hrst = 1'b0; expect_in(1, M_PRS, 7'b0, "R7 host_rst released");
    step(2);

    // strobe decode
    sel_n = 0; rd_n = 0; wr_n = 1; expect_in(1, M_IOR | M_IOW, M_IOW, "R1 read decode");
    step(1);
    sel_n = 1; rd_n = 0; expect_in(1, M_IOR | M_IOW, M_IOR | M_IOW, "R1 no select no read");
    step(1);
    sel_n = 0; rd_n = 1; wr_n = 1; expect_in(1, M_IOR | M_IOW, M_IOR | M_IOW, "R1 select alone idle");
    step(1);
    wr_n = 0; expect_in(1, M_IOR | M_IOW, M_IOR, "R2 write decode");
    step(1);
    sel_n = 1; expect_in(1, M_IOR | M_IOW, M_IOR | M_IOW, "R2 no select no write");
    step(1);
    sel_n = 0; rd_n = 0; wr_n = 0; expect_in(1, M_IOR | M_IOW, 7'b0, "R2 both strobes");
    step(1);
    sel_n = 1; rd_n = 1; wr_n = 1;
    step(2);

    // interrupt inversion
    irq = 1; expect_in(2, M_IRQ, M_IRQ, "R6 irq not early"); expect_in(3, M_IRQ, 7'b0, "R6 irq inverted");
    step(4);
    irq = 0; expect_in(3, M_IRQ, M_IRQ, "R6 irq released");
    step(5);

    // acknowledge with no pending hold is ignored
    hack_n = 0; expect_in(3, M_HLA | M_OWN | M_HLD, M_HLD, "R5 stray ack ignored");
    expect_in(5, M_HLA | M_OWN, 7'b0, "R5 stray ack ignored later");
    step(6);
    hack_n = 1;
    step(5);

    // full grant cycle with host strobes held active
    sel_n = 0; rd_n = 0;
    hreq = 1;
    expect_in(2, M_HLD | M_IOR, M_HLD, "R3 hold not early");
    expect_in(3, M_HLD | M_OWN | M_IOR, 7'b0, "R3 hold falls");
    step(5);
    hack_n = 0;
    expect_in(2, M_HLA | M_OWN, 7'b0, "R5 grant not early");
    expect_in(3, M_HLA | M_OWN | M_HLD | M_IOR | M_IOW, M_HLA | M_OWN | M_IOR | M_IOW,
              "R8 R10 grant and strobes blocked");
    step(5);
    hreq = 0;
    expect_in(3, M_HLD | M_HLA | M_OWN | M_IOR, M_HLD | M_HLA | M_OWN | M_IOR, "R4 hold released owner kept");
    step(4);
    hreq = 1;  // re-request during release
    expect_in(4, M_HLD | M_OWN, M_HLD | M_OWN, "R9 no early fall");
    step(6);
    hack_n = 1;
    expect_in(3, M_HLD | M_HLA | M_OWN | M_IOR, M_HLD, "R5 R10 ownership returns");
    expect_in(4, M_HLD | M_OWN, 7'b0, "R9 single new fall");
    step(6);

    // abort before grant
    hreq = 0;
    expect_in(2, M_HLD, 7'b0, "R4 abort not early");
    expect_in(3, M_HLD | M_OWN | M_HLA, M_HLD, "R4 abort restores hold");
    step(5);
    sel_n = 1; rd_n = 1;
    step(4);

    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule